// File: doc/BRIEF.md
# Tagged Two-Phase Read Sequencer

This block runs one register read on the host side against a peripheral that executes commands some time after it receives them. The read is split into two link transfers. A pre-fetch carries the opcode, a parameter word and a 2-bit transaction tag. An activate transfer later collects the data. Between the two, the sequencer polls the peripheral's status byte until the echoed tag equals the tag it sent and the data-ready flag is set. After the activate it reads status once more and sorts the outcome into success, success with a background warning, or failure.

Two valid/ready streams face the user. The start stream accepts a command only while the sequencer is idle. The result stream holds code, data and flags stable until the consumer takes them, so a slow consumer stalls the sequencer in its final state. On the link side, each request stays valid with stable fields until the link engine accepts it. The engine then returns exactly one response. The sequencer ignores `link_rsp_valid` until its request has been accepted, and it consumes the response in the cycle it is seen. A shutdown flag in any status read abandons the transaction and raises a level output. That output stays high until the next start is accepted.

Top module: `host_read_seq`

## Requirements
- R1: `start_ready` is high only when no transaction is in flight and no result is pending. A start presented at other times is not taken.
- R2: The first link request after a start is a pre-fetch (op code 0). It carries the start opcode, the start parameter and the start tag.
- R3: The status byte layout is: bit0 communication error, bit1 command error, bit2 BIST error, bit3 operational error, bit4 data ready, bit5 shutdown, bits 7:6 echoed tag. While the echoed tag differs from the latched tag, the sequencer issues only further status reads (op code 2).
- R4: A status read whose tag matches but whose bit4 is clear also leads only to another status read.
- R5: A matching tag with bit4 set leads to one activate (op code 1) and then one status read. A clean final status returns code 0 and the activate data.
- R6: Bit5 set in any status read ends the transaction at once with code 5 and data 0, ahead of every other flag. `shutdown` goes high, no further request is issued, and `shutdown` drops when the next start is accepted.
- R7: Bit0 or bit1 set in a pre-fetch-phase status read leads to an error-history read (op code 3) and then a clear (op code 4). The result is code 2, with the history word as data.
- R8: Bit0 or bit1 set in the post-activate status read leads to an error-history read only. The result is code 3, with the history word as data, even when bit2 or bit3 is also set.
- R9: Bit2 or bit3 set without bit0 or bit1 in the post-activate status read returns code 1 with the activate data.
- R10: When `poll_limit` status reads in the polling phase (latched at start; 0 counts as 1) have not shown a matching tag with data ready, the result is code 4 with data 0.
- R11: A link request holds valid, op, opcode, tag and payload stable until `link_req_ready` is seen.
- R12: A result stays valid with stable code and data until `res_ready`. `res_flags` carries bits 3:0 of the last status byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start command offered |
| start_ready | output | 1 | Sequencer idle, start taken |
| start_opcode | input | 8 | Read opcode for the pre-fetch |
| start_param | input | PW | Parameter word for the pre-fetch |
| start_tag | input | 2 | Transaction tag |
| poll_limit | input | PCW | Maximum polling-phase status reads |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result consumer accepts |
| res_code | output | 3 | 0 ok, 1 warn, 2 pre-fetch fail, 3 activate fail, 4 timeout, 5 shutdown |
| res_data | output | DW | Read data or error-history word |
| res_flags | output | 4 | Error bits of last status byte |
| shutdown | output | 1 | Emergency shutdown seen |
| link_req_valid | output | 1 | Link request offered |
| link_req_ready | input | 1 | Link engine accepts request |
| link_req_op | output | 3 | 0 pre-fetch, 1 activate, 2 status, 3 error history, 4 clear |
| link_req_opcode | output | 8 | Opcode (pre-fetch only, else 0) |
| link_req_tag | output | 2 | Latched tag |
| link_req_payload | output | PW | Parameter (pre-fetch only, else 0) |
| link_rsp_valid | input | 1 | Response for accepted request |
| link_rsp_data | input | DW | Status byte in bits 7:0, or data word |

## Verification
The bench feeds status sequences in which the tag is stale several times, or matches while data is not yet ready. A design that checked only one of the two conditions would issue the activate too early, and the op log would show it. Shutdown is mixed with error bits, in both the polling and final phases, to expose a design that gives error classes priority over shutdown or keeps issuing requests afterwards. Failures with BIST or operational bits also set are checked to catch misclassification as a warning. Poll limits of 3 and 0 catch off-by-one timeouts, and a stalled result consumer catches a result that changes before it is taken.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  localparam int TAGW = 2;

  typedef enum logic [2:0] {
    OP_PREFETCH = 3'd0,
    OP_ACTIVATE = 3'd1,
    OP_STATUS   = 3'd2,
    OP_ERRHIST  = 3'd3,
    OP_CLEAR    = 3'd4
  } link_op_e;

  typedef enum logic [2:0] {
    RC_OK       = 3'd0,
    RC_WARN     = 3'd1,
    RC_PF_FAIL  = 3'd2,
    RC_ACT_FAIL = 3'd3,
    RC_TIMEOUT  = 3'd4,
    RC_SHUTDOWN = 3'd5
  } res_code_e;

  typedef struct packed {
    logic [TAGW-1:0] tag;
    logic            shut;
    logic            rda;
    logic            oper;
    logic            bist;
    logic            cmd;
    logic            comm;
  } status_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PREFETCH, S_POLL, S_ACTIVATE, S_CHECK, S_ERRHIST, S_CLEAR, S_DONE
  } seq_state_e;
endpackage

// File: rtl/hrs_status_decode.sv
module hrs_status_decode
  import hrs_pkg::*;
(
  input  logic [7:0]      status_byte,
  input  logic [TAGW-1:0] want_tag,
  output logic            is_shut,
  output logic            is_fail,
  output logic            is_warn,
  output logic            is_ready,
  output logic [3:0]      err_bits
);
  status_t st;

  always_comb begin
    st       = status_t'(status_byte);
    is_shut  = st.shut;
    is_fail  = st.comm | st.cmd;
    is_warn  = st.bist | st.oper;
    is_ready = (st.tag == want_tag) && st.rda;
    err_bits = {st.oper, st.bist, st.cmd, st.comm};
  end
endmodule

// File: rtl/hrs_poll_ctr.sv
module hrs_poll_ctr #(
  parameter int PCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  input  logic [PCW-1:0] limit,
  output logic           last
);
  logic [PCW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // reads done so far, including the one being classified now
  always_comb last = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};

  assert_ctl_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && inc));
endmodule

// File: rtl/hrs_link_port.sv
module hrs_link_port (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic rsp_take
);
  logic issued;

  always_comb begin
    req_valid = want && !issued;
    rsp_take  = want && issued && rsp_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       issued <= 1'b0;
    else if (req_valid && req_ready)  issued <= 1'b1;
    else if (rsp_take)                issued <= 1'b0;
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);
endmodule

// File: rtl/host_read_seq.sv
module host_read_seq
  import hrs_pkg::*;
#(
  parameter int DW  = 32,
  parameter int PW  = 16,
  parameter int PCW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_valid,
  output logic            start_ready,
  input  logic [7:0]      start_opcode,
  input  logic [PW-1:0]   start_param,
  input  logic [1:0]      start_tag,
  input  logic [PCW-1:0]  poll_limit,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [2:0]      res_code,
  output logic [DW-1:0]   res_data,
  output logic [3:0]      res_flags,
  output logic            shutdown,
  output logic            link_req_valid,
  input  logic            link_req_ready,
  output logic [2:0]      link_req_op,
  output logic [7:0]      link_req_opcode,
  output logic [1:0]      link_req_tag,
  output logic [PW-1:0]   link_req_payload,
  input  logic            link_rsp_valid,
  input  logic [DW-1:0]   link_rsp_data
);
  seq_state_e      state;
  logic [TAGW-1:0] tag_q;
  logic [7:0]      opcode_q;
  logic [PW-1:0]   param_q;
  logic [PCW-1:0]  limit_q;
  res_code_e       code_q;
  logic [DW-1:0]   data_q;
  logic [3:0]      flags_q;
  logic            shut_q;

  logic want, rsp_take;
  logic d_shut, d_fail, d_warn, d_ready;
  logic [3:0] d_bits;
  logic poll_last;

  hrs_status_decode u_dec (
    .status_byte (link_rsp_data[7:0]),
    .want_tag    (tag_q),
    .is_shut     (d_shut),
    .is_fail     (d_fail),
    .is_warn     (d_warn),
    .is_ready    (d_ready),
    .err_bits    (d_bits)
  );

  hrs_poll_ctr #(.PCW(PCW)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state == S_PREFETCH),
    .inc   ((state == S_POLL) && rsp_take),
    .limit (limit_q),
    .last  (poll_last)
  );

  hrs_link_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (want),
    .req_ready (link_req_ready),
    .rsp_valid (link_rsp_valid),
    .req_valid (link_req_valid),
    .rsp_take  (rsp_take)
  );

  always_comb begin
    want             = 1'b1;
    link_req_op      = OP_STATUS;
    link_req_opcode  = '0;
    link_req_payload = '0;
    case (state)
      S_PREFETCH: begin
        link_req_op      = OP_PREFETCH;
        link_req_opcode  = opcode_q;
        link_req_payload = param_q;
      end
      S_ACTIVATE: link_req_op = OP_ACTIVATE;
      S_ERRHIST:  link_req_op = OP_ERRHIST;
      S_CLEAR:    link_req_op = OP_CLEAR;
      S_POLL, S_CHECK: link_req_op = OP_STATUS;
      default:    want = 1'b0;
    endcase
  end

  always_comb begin
    start_ready  = (state == S_IDLE);
    res_valid    = (state == S_DONE);
    res_code     = code_q;
    res_data     = data_q;
    res_flags    = flags_q;
    shutdown     = shut_q;
    link_req_tag = tag_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tag_q    <= '0;
      opcode_q <= '0;
      param_q  <= '0;
      limit_q  <= '0;
      code_q   <= RC_OK;
      data_q   <= '0;
      flags_q  <= '0;
      shut_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_valid) begin
          tag_q    <= start_tag;
          opcode_q <= start_opcode;
          param_q  <= start_param;
          limit_q  <= poll_limit;
          data_q   <= '0;
          flags_q  <= '0;
          code_q   <= RC_OK;
          shut_q   <= 1'b0;
          state    <= S_PREFETCH;
        end
        S_PREFETCH: if (rsp_take) state <= S_POLL;
        S_POLL: if (rsp_take) begin
          flags_q <= d_bits;
          if (d_shut) begin
            code_q <= RC_SHUTDOWN;
            shut_q <= 1'b1;
            state  <= S_DONE;
          end else if (d_fail) begin
            code_q <= RC_PF_FAIL;
            state  <= S_ERRHIST;
          end else if (d_ready) begin
            state  <= S_ACTIVATE;
          end else if (poll_last) begin
            code_q <= RC_TIMEOUT;
            state  <= S_DONE;
          end
        end
        S_ACTIVATE: if (rsp_take) begin
          data_q <= link_rsp_data;
          state  <= S_CHECK;
        end
        S_CHECK: if (rsp_take) begin
          flags_q <= d_bits;
          if (d_shut) begin
            code_q <= RC_SHUTDOWN;
            data_q <= '0;
            shut_q <= 1'b1;
            state  <= S_DONE;
          end else if (d_fail) begin
            code_q <= RC_ACT_FAIL;
            state  <= S_ERRHIST;
          end else begin
            code_q <= d_warn ? RC_WARN : RC_OK;
            state  <= S_DONE;
          end
        end
        S_ERRHIST: if (rsp_take) begin
          data_q <= link_rsp_data;
          state  <= (code_q == RC_PF_FAIL) ? S_CLEAR : S_DONE;
        end
        S_CLEAR: if (rsp_take) state <= S_DONE;
        S_DONE:  if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !res_valid && !link_req_valid);

  assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    link_req_valid && !link_req_ready |=>
      $stable(link_req_op) && $stable(link_req_tag) &&
      $stable(link_req_opcode) && $stable(link_req_payload));

  assert_res_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_code) && $stable(res_data));

  assert_shut_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_code == 3'd5 |-> shutdown);

  assert_shut_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !link_req_valid);
endmodule

// File: tb/test_host_read_seq.sv
module test_host_read_seq;
  localparam int DW = 32, PW = 16, PCW = 8;
  localparam int F_COMM = 1, F_CMD = 2, F_BIST = 4, F_OPER = 8, F_RDA = 16, F_SHUT = 32;

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, start_ready;
  logic [7:0] start_opcode = 0;
  logic [PW-1:0] start_param = 0;
  logic [1:0] start_tag = 0;
  logic [PCW-1:0] poll_limit = 8'd20;
  logic res_valid, res_ready = 0;
  logic [2:0] res_code;
  logic [DW-1:0] res_data;
  logic [3:0] res_flags;
  logic shutdown;
  logic link_req_valid, link_req_ready = 0;
  logic [2:0] link_req_op;
  logic [7:0] link_req_opcode;
  logic [1:0] link_req_tag;
  logic [PW-1:0] link_req_payload;
  logic link_rsp_valid = 0;
  logic [DW-1:0] link_rsp_data = 0;

  host_read_seq #(.DW(DW), .PW(PW), .PCW(PCW)) i_host_read_seq (.*);

  always #5 clk = ~clk;

  int nvec = 0, nfail = 0, done_cnt = 0, hold_cycles = 0, lk_n = 0;
  bit finished = 0;
  logic [7:0] stat_q[$];
  int exp_ops[$], got_ops[$];
  int exp_code_q[$];
  logic [DW-1:0] exp_data_q[$];
  logic [3:0] exp_flags_q[$];
  logic [DW-1:0] act_word, eh_word;
  logic [7:0] cur_op;
  logic [PW-1:0] cur_param;
  logic [1:0] cur_tag;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stb(input int tag, input int bits);
    return {tag[1:0], bits[5:0]};
  endfunction

  // link engine model
  initial forever begin
    @(negedge clk);
    if (link_req_valid) begin
      logic [2:0] op0; logic [7:0] oc0; logic [1:0] tg0; logic [PW-1:0] pl0;
      op0 = link_req_op; oc0 = link_req_opcode; tg0 = link_req_tag; pl0 = link_req_payload;
      for (int d = 0; d < lk_n % 3; d++) @(negedge clk);
      chk(link_req_valid && link_req_op == op0 && link_req_payload == pl0 &&
          link_req_tag == tg0 && link_req_opcode == oc0, "R11 request held", {29'd0, link_req_op}, {29'd0, op0});
      if (op0 == 3'd0)
        chk(oc0 == cur_op && pl0 == cur_param && tg0 == cur_tag, "R2 prefetch fields",
            {8'd0, oc0, pl0}, {8'd0, cur_op, cur_param});
      link_req_ready = 1;
      @(negedge clk);
      link_req_ready = 0;
      got_ops.push_back(int'(op0));
      for (int d = 0; d < lk_n % 2; d++) @(negedge clk);
      lk_n++;
      case (op0)
        3'd1: link_rsp_data = act_word;
        3'd2: link_rsp_data = (stat_q.size() > 0) ? {24'd0, stat_q.pop_front()} : 32'h0;
        3'd3: link_rsp_data = eh_word;
        default: link_rsp_data = 32'h0;
      endcase
      link_rsp_valid = 1;
      @(negedge clk);
      link_rsp_valid = 0;
    end
  end

  // result monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (res_valid) begin
      logic [2:0] c0; logic [DW-1:0] d0; bit held; bit ops_ok; int ec;
      c0 = res_code; d0 = res_data; held = 1;
      for (int k = 0; k < hold_cycles; k++) begin
        @(negedge clk);
        if (!res_valid || res_code !== c0 || res_data !== d0) held = 0;
      end
      chk(held, "R12 result held", {29'd0, res_code}, {29'd0, c0});
      ec = exp_code_q.pop_front();
      chk(res_code == ec[2:0], "R5-R10 code", {29'd0, res_code}, ec);
      chk(res_data == exp_data_q[0], "R5 data", res_data, exp_data_q[0]);
      void'(exp_data_q.pop_front());
      chk(res_flags == exp_flags_q[0], "R12 flags", {28'd0, res_flags}, {28'd0, exp_flags_q[0]});
      void'(exp_flags_q.pop_front());
      chk(shutdown == (ec == 5), "R6 shutdown level", {31'd0, shutdown}, {31'd0, ec == 5});
      ops_ok = (got_ops.size() == exp_ops.size());
      if (ops_ok) foreach (got_ops[i]) if (got_ops[i] != exp_ops[i]) ops_ok = 0;
      chk(ops_ok, "R3 R4 R7 R8 op sequence", got_ops.size(), exp_ops.size());
      res_ready = 1;
      @(negedge clk);
      res_ready = 0;
      done_cnt++;
    end
  end

  task automatic go(input logic [7:0] oc, input logic [PW-1:0] pm, input logic [1:0] tg,
                    input logic [PCW-1:0] lim, input int code, input logic [DW-1:0] data, input int hold);
    int target;
    bit was_shut;
    was_shut = shutdown;
    exp_code_q.push_back(code);
    exp_data_q.push_back(data);
    exp_flags_q.push_back(stat_q[stat_q.size()-1][3:0]);
    got_ops.delete();
    cur_op = oc; cur_param = pm; cur_tag = tg; hold_cycles = hold;
    target = done_cnt + 1;
    @(negedge clk);
    start_opcode = oc; start_param = pm; start_tag = tg; poll_limit = lim;
    start_valid = 1;
    while (!start_ready) @(negedge clk);
    @(negedge clk);
    start_valid = 0;
    chk(!start_ready, "R1 busy after start", {31'd0, start_ready}, 0);
    if (was_shut) chk(!shutdown, "R6 shutdown cleared on start", {31'd0, shutdown}, 0);
    wait (done_cnt == target);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    act_word = 32'hCAFE_0001; eh_word = 32'h0BAD_0E11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(start_ready && !res_valid && !link_req_valid && !shutdown, "R1 reset state",
        {28'd0, start_ready, res_valid, link_req_valid, shutdown}, 4'b1000);

    // R5 plain success
    stat_q = '{stb(2, F_RDA), stb(2, 0)};
    exp_ops = '{0, 2, 1, 2};
    go(8'h5C, 16'h1234, 2'd2, 8'd20, 0, act_word, 0);

    // R3 stale tags, R4 tag match without data ready
    act_word = 32'h1111_2222;
    stat_q = '{stb(0, F_RDA), stb(3, 0), stb(1, 0), stb(1, F_RDA), stb(1, 0)};
    exp_ops = '{0, 2, 2, 2, 2, 1, 2};
    go(8'hB5, 16'hABCD, 2'd1, 8'd20, 0, act_word, 3);

    // R9 background warning (BIST) and (operational)
    stat_q = '{stb(3, F_RDA), stb(3, F_BIST)};
    exp_ops = '{0, 2, 1, 2};
    go(8'h06, 16'h0001, 2'd3, 8'd20, 1, act_word, 0);
    stat_q = '{stb(0, F_RDA), stb(0, F_OPER)};
    exp_ops = '{0, 2, 1, 2};
    go(8'h07, 16'h0002, 2'd0, 8'd20, 1, act_word, 1);

    // R7 pre-fetch failure with command error
    stat_q = '{stb(2, F_CMD)};
    exp_ops = '{0, 2, 3, 4};
    go(8'h30, 16'h0003, 2'd2, 8'd20, 2, eh_word, 0);

    // R8 activate failure, comm error outranks BIST
    stat_q = '{stb(1, F_RDA), stb(1, F_COMM | F_BIST)};
    exp_ops = '{0, 2, 1, 2, 3};
    go(8'h31, 16'h0004, 2'd1, 8'd20, 3, eh_word, 2);

    // R6 shutdown during polling, outranks comm error
    stat_q = '{stb(3, 0), stb(3, F_SHUT | F_COMM)};
    exp_ops = '{0, 2, 2};
    go(8'h32, 16'h0005, 2'd3, 8'd20, 5, 32'h0, 2);

    // R6 shutdown after activate, also clears on this start
    stat_q = '{stb(0, F_RDA), stb(0, F_SHUT | F_OPER)};
    exp_ops = '{0, 2, 1, 2};
    go(8'h33, 16'h0006, 2'd0, 8'd20, 5, 32'h0, 0);

    // R10 timeout after three polls, then limit 0 counts as one
    stat_q = '{stb(1, F_RDA), stb(2, F_BIST), stb(0, F_RDA | F_OPER)};
    exp_ops = '{0, 2, 2, 2};
    go(8'h40, 16'h0007, 2'd3, 8'd3, 4, 32'h0, 0);
    stat_q = '{stb(2, 0)};
    exp_ops = '{0, 2};
    go(8'h41, 16'h0008, 2'd2, 8'd0, 4, 32'h0, 0);

    // success after timeouts, tag rolled over
    act_word = 32'h7777_8888;
    stat_q = '{stb(0, 0), stb(0, F_RDA), stb(0, 0)};
    exp_ops = '{0, 2, 2, 1, 2};
    go(8'h42, 16'hFFFF, 2'd0, 8'd2, 0, act_word, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule